// File: doc/BRIEF.md
# Calendar Load Gate and Seconds Prescaler

This block decides when a real-time calendar may be reloaded and turns a slow real-time clock into a one-per-second calendar tick. Software-facing writes arrive in the bus clock domain. The divider chain and the live time and date words sit in the real-time clock domain. A request/acknowledge handshake freezes the divider chain and the live calendar. Configuration writes are accepted only while the freeze is acknowledged, and leaving the freeze restarts everything from the staged values.

A second handshake keeps a bus-side shadow copy of the calendar. Software clears a "shadow valid" flag. The bus side then asks the real-time side for a snapshot, copies it into the shadow, and raises the flag again. A calendar-valid status is derived from the shadow year field. The seconds field steps in BCD on every tick. Minutes, hours and date are carried but never stepped here. A write-protection qualifier arrives as an input and blocks every write while it is low.

Two state machines form the core. The real-time side has the states RC_RUN and RC_FROZEN. It goes RC_RUN→RC_FROZEN when the synchronised freeze request is high, and RC_FROZEN→RC_RUN when the request drops, loading the staged words and divider values on that transition. The bus side resync machine has the states RS_IDLE, RS_ASK and RS_RELEASE, and leaves reset in RS_ASK. Its transitions are:
- RS_IDLE→RS_ASK on a flag-clear command.
- RS_ASK→RS_RELEASE when the synchronised snapshot-done arrives. The shadow is captured and the flag is set on this transition.
- RS_RELEASE→RS_IDLE when done drops and the flag is still set.
- RS_RELEASE→RS_ASK when done drops after a clear was issued during RS_RELEASE.

Top module: `cal_init_ctrl`

## Requirements
- R1: While `wr_unlocked` is 0, no write has any effect: the freeze request, the hour-format bit and all staged words keep their values.
- R2: Writing the control word (select 2) with bit 7 set makes `init_ack` rise after the request crosses to the real-time side and back, which takes a few real-time cycles. Clearing bit 7 makes `init_ack` fall the same way. `init_ack` is 0 after reset.
- R3: Time (select 0), date (select 1) and prescaler (select 3) writes, and the hour-format bit, are accepted only while `init_ack` is 1. Otherwise they are ignored.
- R4: While frozen, `tick_1hz` stays low and the live calendar does not change.
- R5: On leaving the freeze, the live calendar takes the staged words. Prescaler bits 22:16 are the first-stage value A and bits 14:0 are the second-stage value S. `tick_1hz` then pulses for one real-time cycle every (A+1)·(S+1) real-time cycles. Reset values are A=127 and S=255.
- R6: Each tick advances BCD seconds (time bits 6:0) by one, from 59 to 00. Minutes (bits 14:8), hours (bits 21:16) and the date word stay unchanged.
- R7: A control write with bit 5 set clears `resync_ok` at once. The flag sets again once a fresh snapshot of the live time and date is in `time_shadow`/`date_shadow`. After reset the flag is 0 and sets by itself.
- R8: `cal_valid` is 1 exactly when the shadow year field (date bits 23:16) is non-zero. After reset it is 0.
- R9: Control bit 6 drives `hour12` (0 = 24-hour, 1 = AM/PM). It is 0 after reset.
- R10: Unused bits are stored as zero. Time keeps only bits 6:0, 14:8 and 21:16. Date keeps bits 5:0 (day), 12:8 (month), 15:13 (weekday, 1 = Monday to 7 = Sunday) and 23:16 (year).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| clk_rtc | input | 1 | Real-time clock feeding the dividers |
| rst_n | input | 1 | Asynchronous active-low reset of both domains |
| wr_en | input | 1 | Write strobe, bus domain |
| wr_sel | input | 2 | Word select: 0 time, 1 date, 2 control, 3 prescaler |
| wr_data | input | 32 | Write data |
| wr_unlocked | input | 1 | Write-protection qualifier, 1 allows writes |
| init_ack | output | 1 | Freeze acknowledged; configuration writes allowed |
| resync_ok | output | 1 | Shadow copy is fresh |
| cal_valid | output | 1 | Shadow year is non-zero |
| hour12 | output | 1 | Hour format selection |
| tick_1hz | output | 1 | One-cycle calendar tick, real-time domain |
| time_shadow | output | 24 | Bus-side copy of the live time word |
| date_shadow | output | 24 | Bus-side copy of the live date word |

## Verification
Several faults show up at the ports in predictable ways:
- A stuck or mis-sequenced freeze machine shows as `init_ack` never moving, or as ticks that continue while frozen. Both are visible within a few hundred real-time cycles.
- A divider that reloads wrongly gives a tick interval that differs from (A+1)·(S+1). The tick-interval scoreboard catches this on the second tick after a reconfiguration.
- A bad seconds step or a lost staged word appears in the shadow after the next resync.
- A broken resync machine leaves `resync_ok` low, and the bench's bounded wait reports it within about eighty bus cycles.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int DATA_W  = 32;
    localparam int CAL_W   = 24;
    localparam int ADIV_W  = 7;
    localparam int SDIV_W  = 15;
    localparam int SEC_W   = 7;
    localparam int YEAR_W  = 8;
    localparam int YEAR_LSB = 16;
    localparam int ADIV_LSB = 16;
    localparam int SDIV_LSB = 0;
    localparam int CTL_INIT_BIT   = 7;
    localparam int CTL_FMT_BIT    = 6;
    localparam int CTL_RSFCLR_BIT = 5;
    localparam logic [CAL_W-1:0] TIME_KEEP = 24'h3F7F7F;
    localparam logic [CAL_W-1:0] DATE_KEEP = 24'hFFFF3F;
    localparam logic [ADIV_W-1:0] ADIV_RST = 7'h7F;
    localparam logic [SDIV_W-1:0] SDIV_RST = 15'h00FF;

    typedef enum logic [1:0] {
        SEL_TIME  = 2'd0,
        SEL_DATE  = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_PRESC = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RC_RUN    = 1'b0,
        RC_FROZEN = 1'b1
    } rtc_state_e;

    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_ASK     = 2'd1,
        RS_RELEASE = 2'd2
    } rs_state_e;

    typedef struct packed {
        logic [ADIV_W-1:0] adiv;
        logic [SDIV_W-1:0] sdiv;
    } presc_t;

    function automatic logic [SEC_W-1:0] sec_step(input logic [SEC_W-1:0] s);
        if (s[6:4] >= 3'd5 && s[3:0] >= 4'd9)
            return '0;
        else if (s[3:0] >= 4'd9)
            return {s[6:4] + 3'd1, 4'd0};
        else
            return s + 7'd1;
    endfunction
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cal_rtc_core.sv
module cal_rtc_core
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_req,
    input  logic             snap_req,
    input  logic [CAL_W-1:0] time_ld,
    input  logic [CAL_W-1:0] date_ld,
    input  presc_t           presc_ld,
    output logic             frozen,
    output logic             snap_done,
    output logic             tick,
    output logic [CAL_W-1:0] snap_time,
    output logic [CAL_W-1:0] snap_date
);
    rtc_state_e state, state_nx;
    logic [ADIV_W-1:0] a_cnt, a_top;
    logic [SDIV_W-1:0] s_cnt, s_top;
    logic [CAL_W-1:0]  time_r, date_r;
    logic a_end, s_end, leave;

    assign a_end = (a_cnt == '0);
    assign s_end = (s_cnt == '0);
    assign leave = (state == RC_FROZEN) && !freeze_req;
    assign frozen = (state == RC_FROZEN);

    always_comb begin
        state_nx = state;
        unique case (state)
            RC_RUN:    if (freeze_req)  state_nx = RC_FROZEN;
            RC_FROZEN: if (!freeze_req) state_nx = RC_RUN;
            default:   state_nx = RC_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RC_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_top  <= ADIV_RST;
            s_top  <= SDIV_RST;
            a_cnt  <= ADIV_RST;
            s_cnt  <= SDIV_RST;
            time_r <= '0;
            date_r <= '0;
            tick   <= 1'b0;
        end else if (leave) begin
            a_top  <= presc_ld.adiv;
            s_top  <= presc_ld.sdiv;
            a_cnt  <= presc_ld.adiv;
            s_cnt  <= presc_ld.sdiv;
            time_r <= time_ld & TIME_KEEP;
            date_r <= date_ld & DATE_KEEP;
            tick   <= 1'b0;
        end else if (state == RC_RUN) begin
            tick <= a_end && s_end;
            if (a_end) begin
                a_cnt <= a_top;
                if (s_end) begin
                    s_cnt <= s_top;
                    time_r[SEC_W-1:0] <= sec_step(time_r[SEC_W-1:0]);
                end else begin
                    s_cnt <= s_cnt - 1'b1;
                end
            end else begin
                a_cnt <= a_cnt - 1'b1;
            end
        end else begin
            tick <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_done <= 1'b0;
            snap_time <= '0;
            snap_date <= '0;
        end else if (snap_req && !snap_done) begin
            snap_done <= 1'b1;
            snap_time <= time_r;
            snap_date <= date_r;
        end else if (!snap_req) begin
            snap_done <= 1'b0;
        end
    end

    // R4: a settled freeze produces no tick and holds the calendar
    p_frozen_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RC_FROZEN && $past(state) == RC_FROZEN)
            |-> (!tick && $stable(time_r) && $stable(date_r)));

    // R6: seconds move only on a tick edge
    p_sec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RC_RUN && $past(state) == RC_RUN && !tick)
            |-> $stable(time_r[SEC_W-1:0]));

    // R6: minutes, hours and date never step while running
    p_upper_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RC_RUN && $past(state) == RC_RUN)
            |-> ($stable(time_r[CAL_W-1:8]) && $stable(date_r)));

    // R7: the snapshot holds still while it is offered
    p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_done && $past(snap_done)) |-> ($stable(snap_time) && $stable(snap_date)));
endmodule

// File: rtl/cal_bus_regs.sv
module cal_bus_regs
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_unlocked,
    input  logic              ack_s,
    input  logic              done_s,
    input  logic [CAL_W-1:0]  snap_time,
    input  logic [CAL_W-1:0]  snap_date,
    output logic              init_q,
    output logic              fmt_q,
    output logic              pend_q,
    output logic              rsf_q,
    output logic [CAL_W-1:0]  time_stage,
    output logic [CAL_W-1:0]  date_stage,
    output presc_t            presc_stage,
    output logic [CAL_W-1:0]  time_sh,
    output logic [CAL_W-1:0]  date_sh
);
    rs_state_e rs, rs_nx;
    logic wr_ok, cfg_ok, ctl_wr, clr_cmd;
    logic unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:CAL_W];
    assign wr_ok   = wr_en && wr_unlocked;
    assign cfg_ok  = wr_ok && ack_s;
    assign ctl_wr  = wr_ok && (wr_sel == SEL_CTRL);
    assign clr_cmd = ctl_wr && wr_data[CTL_RSFCLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q      <= 1'b0;
            fmt_q       <= 1'b0;
            time_stage  <= '0;
            date_stage  <= '0;
            presc_stage <= '{adiv: ADIV_RST, sdiv: SDIV_RST};
        end else begin
            if (ctl_wr) begin
                init_q <= wr_data[CTL_INIT_BIT];
                if (ack_s) fmt_q <= wr_data[CTL_FMT_BIT];
            end
            if (cfg_ok && wr_sel == SEL_TIME) time_stage <= wr_data[CAL_W-1:0] & TIME_KEEP;
            if (cfg_ok && wr_sel == SEL_DATE) date_stage <= wr_data[CAL_W-1:0] & DATE_KEEP;
            if (cfg_ok && wr_sel == SEL_PRESC) begin
                presc_stage.adiv <= wr_data[ADIV_LSB +: ADIV_W];
                presc_stage.sdiv <= wr_data[SDIV_LSB +: SDIV_W];
            end
        end
    end

    always_comb begin
        rs_nx = rs;
        unique case (rs)
            RS_IDLE:    if (clr_cmd) rs_nx = RS_ASK;
            RS_ASK:     if (done_s)  rs_nx = RS_RELEASE;
            RS_RELEASE: if (!done_s) rs_nx = (rsf_q && !clr_cmd) ? RS_IDLE : RS_ASK;
            default:    rs_nx = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs <= RS_ASK;
        else        rs <= rs_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b1;
            rsf_q   <= 1'b0;
            time_sh <= '0;
            date_sh <= '0;
        end else begin
            pend_q <= (rs_nx == RS_ASK);
            if (rs == RS_ASK && done_s) begin
                time_sh <= snap_time;
                date_sh <= snap_date;
            end
            if (clr_cmd)
                rsf_q <= 1'b0;
            else if (rs == RS_ASK && done_s)
                rsf_q <= 1'b1;
        end
    end

    // R1: a locked port changes nothing
    p_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_unlocked) |-> ($stable(init_q) && $stable(fmt_q) && $stable(time_stage)
                                 && $stable(date_stage) && $stable(presc_stage)));

    // R3: configuration only moves while the freeze is acknowledged
    p_cfg_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack_s) |-> ($stable(time_stage) && $stable(date_stage)
                           && $stable(presc_stage) && $stable(fmt_q)));

    // R7: the flag only rises on a delivered snapshot
    p_rsf_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsf_q) |-> $past(done_s));
endmodule

// File: rtl/cal_init_ctrl.sv
module cal_init_ctrl
    import cal_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_bus,
    input  logic              clk_rtc,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_unlocked,
    output logic              init_ack,
    output logic              resync_ok,
    output logic              cal_valid,
    output logic              hour12,
    output logic              tick_1hz,
    output logic [CAL_W-1:0]  time_shadow,
    output logic [CAL_W-1:0]  date_shadow
);
    logic init_q, pend_q, freeze_rtc, snap_rtc, frozen, snap_done, done_bus;
    logic [CAL_W-1:0] time_stage, date_stage, snap_time, snap_date;
    presc_t presc_stage;

    cal_bus_regs u_bus (
        .clk(clk_bus), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .wr_unlocked(wr_unlocked), .ack_s(init_ack),
        .done_s(done_bus), .snap_time(snap_time), .snap_date(snap_date),
        .init_q(init_q), .fmt_q(hour12), .pend_q(pend_q), .rsf_q(resync_ok),
        .time_stage(time_stage), .date_stage(date_stage), .presc_stage(presc_stage),
        .time_sh(time_shadow), .date_sh(date_shadow)
    );

    cal_sync #(.STAGES(SYNC_STAGES)) u_sync_init (.clk(clk_rtc), .rst_n(rst_n), .d(init_q),    .q(freeze_rtc));
    cal_sync #(.STAGES(SYNC_STAGES)) u_sync_pend (.clk(clk_rtc), .rst_n(rst_n), .d(pend_q),    .q(snap_rtc));
    cal_sync #(.STAGES(SYNC_STAGES)) u_sync_ack  (.clk(clk_bus), .rst_n(rst_n), .d(frozen),    .q(init_ack));
    cal_sync #(.STAGES(SYNC_STAGES)) u_sync_done (.clk(clk_bus), .rst_n(rst_n), .d(snap_done), .q(done_bus));

    cal_rtc_core u_rtc (
        .clk(clk_rtc), .rst_n(rst_n), .freeze_req(freeze_rtc), .snap_req(snap_rtc),
        .time_ld(time_stage), .date_ld(date_stage), .presc_ld(presc_stage),
        .frozen(frozen), .snap_done(snap_done), .tick(tick_1hz),
        .snap_time(snap_time), .snap_date(snap_date)
    );

    assign cal_valid = (date_shadow[YEAR_LSB +: YEAR_W] != '0);
endmodule

// File: tb/test_cal_init_ctrl.sv
module test_cal_init_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RTC_PERIOD = 26;

    logic clk_bus = 1'b0, clk_rtc = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, wr_unlocked = 1'b1;
    logic [1:0] wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic init_ack, resync_ok, cal_valid, hour12, tick_1hz;
    logic [23:0] time_shadow, date_shadow;

    int checks = 0, errors = 0, ticks_seen = 0;
    int exp_q[$];
    logic [31:0] ctl = '0;

    always #(CLK_PERIOD/2) clk_bus = ~clk_bus;
    always #(RTC_PERIOD/2) clk_rtc = ~clk_rtc;

    cal_init_ctrl i_cal_init_ctrl (
        .clk_bus(clk_bus), .clk_rtc(clk_rtc), .rst_n(rst_n), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .wr_unlocked(wr_unlocked),
        .init_ack(init_ack), .resync_ok(resync_ok), .cal_valid(cal_valid),
        .hour12(hour12), .tick_1hz(tick_1hz), .time_shadow(time_shadow),
        .date_shadow(date_shadow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk_bus);
        wr_en = 1'b0;
    endtask

    task automatic wait_ack(input logic lvl, output bit ok);
        ok = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk_bus);
            if (init_ack === lvl) begin ok = 1; break; end
        end
    endtask

    task automatic set_ctl(input logic [31:0] v);
        ctl = v;
        wr(2'd2, v);
    endtask

    task automatic enter_init(input string tag);
        bit ok;
        set_ctl(ctl | 32'h80);
        wait_ack(1'b1, ok);
        check(tag, ok, 1);
    endtask

    task automatic leave_init(input string tag);
        bit ok;
        set_ctl(ctl & ~32'h80);
        wait_ack(1'b0, ok);
        check(tag, ok, 1);
    endtask

    task automatic resync(input string tag);
        bit ok;
        wr(2'd2, ctl | 32'h20);
        check({tag, " flag dropped"}, resync_ok, 0);
        ok = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk_bus);
            if (resync_ok === 1'b1) begin ok = 1; break; end
        end
        check({tag, " flag restored"}, ok, 1);
    endtask

    // scoreboard monitor: compares measured tick intervals against queued expectations
    initial begin : monitor
        int cnt;
        bit armed;
        cnt = 0; armed = 0;
        forever begin
            @(negedge clk_rtc);
            cnt++;
            if (exp_q.size() == 0) armed = 0;
            if (tick_1hz === 1'b1) begin
                ticks_seen++;
                if (exp_q.size() != 0) begin
                    if (!armed) armed = 1;
                    else check("R5 tick period", cnt, exp_q.pop_front());
                end
                cnt = 0;
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic run_config(input int a, input int s);
        enter_init("R2 ack for divider config");
        wr(2'd3, (a << 16) | s);
        leave_init("R2 ack release after divider config");
        for (int k = 0; k < 3; k++) exp_q.push_back((a + 1) * (s + 1));
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk_rtc);
            if (exp_q.size() == 0) break;
        end
        check("R5 expected ticks consumed", exp_q.size(), 0);
    endtask

    initial begin : driver
        int n0;
        #(CLK_PERIOD * 3 + 3);
        rst_n = 1'b1;
        @(negedge clk_bus);
        check("R2 reset init_ack", init_ack, 0);
        check("R7 reset resync_ok", resync_ok, 0);
        check("R8 reset cal_valid", cal_valid, 0);
        check("R9 reset hour12", hour12, 0);
        check("R5 reset tick", tick_1hz, 0);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk_bus);
            if (resync_ok === 1'b1) break;
        end
        check("R7 flag sets after reset", resync_ok, 1);

        // R1: locked port
        wr_unlocked = 1'b0;
        wr(2'd2, 32'h80);
        repeat (60) @(negedge clk_bus);
        check("R1 locked init request ignored", init_ack, 0);
        wr_unlocked = 1'b1;

        // R3: config outside init ignored
        wr(2'd0, 32'h0012_3456);
        set_ctl(32'h40);
        check("R3 format ignored outside init", hour12, 0);
        set_ctl(32'h0);
        wr(2'd2, 32'h80);
        ctl = 32'h80;
        check("R2 ack not immediate", init_ack, 0);
        enter_init("R2 ack rises");
        check("R9 format still 24h", hour12, 0);
        leave_init("R2 ack falls");
        resync("R7 after ignored write");
        check("R3 time write outside init ignored", time_shadow, 32'h0);

        // R10 + R9: full-ones words with slow divider
        enter_init("R2 ack for masking");
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
        set_ctl(32'hC0);
        check("R9 format set in init", hour12, 1);
        leave_init("R2 release after masking");
        resync("R7 masking");
        check("R10 time masked", time_shadow, 32'h3F7F7F);
        check("R10 date masked", date_shadow, 32'hFFFF3F);
        check("R8 year non-zero valid", cal_valid, 1);

        // R6: seconds rollover, A=3 S=49 (200 cycles)
        enter_init("R2 ack for rollover");
        wr(2'd0, 32'h0012_3458);
        wr(2'd1, 32'h0025_A715);
        wr(2'd3, (3 << 16) | 49);
        leave_init("R2 release for rollover");
        n0 = ticks_seen;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk_rtc);
            if (ticks_seen >= n0 + 2) break;
        end
        check("R6 two ticks arrived", ticks_seen - n0, 2);
        repeat (50) @(negedge clk_rtc);
        resync("R7 rollover");
        check("R6 seconds wrapped, upper fields kept", time_shadow, 32'h123400);
        check("R6 date untouched", date_shadow, 32'h25A715);

        // R5 scoreboard: two divider settings, R4 freeze in between
        run_config(1, 2);
        enter_init("R2 ack for freeze");
        n0 = ticks_seen;
        repeat (300) @(negedge clk_rtc);
        check("R4 no tick while frozen", ticks_seen, n0);
        leave_init("R2 release after freeze");
        run_config(3, 4);

        // R8: year zero
        enter_init("R2 ack for year zero");
        wr(2'd1, 32'h0000_0101);
        leave_init("R2 release year zero");
        resync("R7 year zero");
        check("R8 year zero invalid", cal_valid, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule